// File: doc/BRIEF.md
# Compressed and Full-Width Hint Classifier

This block sits in an instruction decode stage next to the main decoder. Each cycle it takes one instruction word, a valid flag and a mode bit that selects the 32-bit or 64-bit base width. It reports whether the word falls in one of the encoding spaces that the architecture reserves for hints or for future fence variants. A core must retire those words as no-ops and must not raise an illegal-instruction trap on them.

When a word matches, the block raises a hint flag and gives a category code that names the form. It also returns the operand fields that form carries: an immediate, a destination register index and a source register index. Every output is registered, so results appear one clock after the word is presented. The main decoder uses the hint flag to suppress its illegal-instruction path and turn the word into a no-op.

A word whose two low bits are `11` is a 32-bit encoding. Any other value is a 16-bit compressed encoding held in bits 15:0, and bits 31:16 are then ignored.

Top module: `hint_nop_classifier`

## Requirements
- R1: A synchronous reset clears every output on the following clock edge: `out_valid`=0, `out_hint`=0, `out_cat`=0 (none), and `out_imm`, `out_rd`, `out_rs` all zero.
- R2: Every output reflects the inputs sampled on the previous rising edge, and `out_valid` equals `in_valid` delayed by exactly one cycle.
- R3: When `in_valid` is 0, the next cycle shows `out_hint`=0, `out_cat`=0 and all three field outputs at zero, whatever the word holds.
- R4: Quadrant 01 with funct3 000. If bits 11:7 are zero and the 6-bit immediate {bit 12, bits 6:2} is nonzero, the result is category 1 (compressed NOP hint) with `out_imm` set to that immediate. If bit 12 is 0, bits 6:2 are zero and bits 11:7 are nonzero, the result is category 2 (compressed ADDI hint) with `out_rd`=bits 11:7.
- R5: Quadrant 01 with funct3 010 and bits 11:7 zero gives category 3 (compressed LI hint) for any immediate. Quadrant 01 with funct3 011, bits 11:7 zero and a nonzero immediate gives category 4 (compressed LUI hint). In both cases `out_imm` is {bit 12, bits 6:2}.
- R6: Quadrant 10 with funct3 100, bits 11:7 zero and bits 6:2 nonzero gives category 5 (compressed MV hint) when bit 12 is 0 and category 6 (compressed ADD hint) when bit 12 is 1. In both cases `out_rs`=bits 6:2.
- R7: Quadrant 10 with funct3 000 gives category 7 (compressed SLLI hint) when the shift amount {bit 12, bits 6:2} is zero or bits 11:7 are zero. In 32-bit mode (`rv64_mode`=0) it also needs bit 12 to be 0. The fields are `out_imm`=shift amount and `out_rd`=bits 11:7.
- R8: Quadrant 01 with funct3 100, bit 12 zero and bits 6:2 zero gives category 8 (compressed SRLI hint) when bits 11:10 are 00 and category 9 (compressed SRAI hint) when they are 01. `out_rd` is 8 plus bits 9:7.
- R9: Opcode 0001111 with funct3 000 gives category 10 (reserved fence) when bits 31:28 are neither 0000 nor 1000, or when rs1 (bits 19:15) or rd (bits 11:7) is nonzero. The fields are `out_imm`=bits 31:20, `out_rs`=rs1 and `out_rd`=rd.
- R10: Opcode 0001111 with funct3 001 gives category 11 (reserved instruction-fetch fence) when bits 31:20, rs1 or rd is nonzero. The fields are the same as in R9.
- R11: A valid word that matches no form gives `out_hint`=0, `out_cat`=0 and all fields zero. This covers the plain compressed NOP 0x0001, the standard fences 0x0FF0000F and 0x8330000F, and the plain instruction-fetch fence 0x0000100F.
- R12: Category codes are fixed: 0 none, 1 to 11 as given in R4 to R10. At most one category results per word, and `out_hint` is 1 exactly when `out_cat` is nonzero.
- R13: When bits 1:0 are `11`, only the 32-bit forms are tested. Otherwise only the compressed forms on bits 15:0 are tested, and bits 31:16 have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | The instruction word is valid this cycle |
| in_word | input | 32 | Instruction word; a compressed word sits in bits 15:0 |
| rv64_mode | input | 1 | 1 selects 64-bit base width, 0 selects 32-bit |
| out_valid | output | 1 | `in_valid` delayed by one cycle |
| out_hint | output | 1 | The word is a hint or reserved fence that retires as a no-op |
| out_cat | output | 4 | Category code of the matched form, 0 when none |
| out_imm | output | 12 | Immediate, shift amount or fence bits of the match |
| out_rd | output | 5 | Destination register field of the match |
| out_rs | output | 5 | Source register field of the match |

## Verification
Nearly all of this block is combinational guards followed by one register stage, so a wrong guard appears at the ports on the cycle after the offending word. The result is then a missing hint, a hint where none belongs, or a wrong category, and a core would trap or fail to trap on that word. The tests walk each form across the boundary of each of its zero and nonzero guards and check both sides. They also run the shift-hint word in both width modes and present compressed words with garbage in the upper half. A stuck or mis-timed register stage shows up as results that lag or lead by a cycle in back-to-back streams, or as fields that are not cleared after reset or after an invalid cycle.

// File: rtl/hint_cls_pkg.sv
package hint_cls_pkg;

   localparam int HC_ILEN   = 32;
   localparam int HC_HALF_W = 16;
   localparam int HC_IMM_W  = 12;
   localparam int HC_REG_W  = 5;
   localparam int HC_CAT_W  = 4;
   localparam int HC_CREG_W = 3;
   localparam int HC_CIMM_W = 6;

   typedef enum logic [HC_CAT_W-1:0] {
      HC_NONE       = 4'd0,
      HC_C_NOP      = 4'd1,
      HC_C_ADDI     = 4'd2,
      HC_C_LI       = 4'd3,
      HC_C_LUI      = 4'd4,
      HC_C_MV       = 4'd5,
      HC_C_ADD      = 4'd6,
      HC_C_SLLI     = 4'd7,
      HC_C_SRLI     = 4'd8,
      HC_C_SRAI     = 4'd9,
      HC_FENCE_RSV  = 4'd10,
      HC_FENCEI_RSV = 4'd11
   } hc_cat_e;

   typedef struct packed {
      logic                hit;
      hc_cat_e             cat;
      logic [HC_IMM_W-1:0] imm;
      logic [HC_REG_W-1:0] rd;
      logic [HC_REG_W-1:0] rs;
   } hc_result_t;

   localparam hc_result_t HC_NO_RESULT = '{
      hit: 1'b0, cat: HC_NONE, imm: '0, rd: '0, rs: '0
   };

endpackage

// File: rtl/hint_cls_rvc.sv
module hint_cls_rvc
   import hint_cls_pkg::*;
#(
   parameter int HALF_W = 16,
   parameter int IMM_W  = 12,
   parameter int REG_W  = 5,
   parameter int CREG_W = 3
) (
   input  logic [HALF_W-1:0] half,
   input  logic              rv64,
   output hc_result_t        res
);

   localparam int CIMM_W  = HC_CIMM_W;
   localparam int IMM_PAD = IMM_W - CIMM_W;
   localparam int CBASE_W = REG_W - CREG_W;

   generate
      if (HALF_W != HC_HALF_W) begin : g_bad_half
         $error("hint_cls_rvc: HALF_W must be 16");
      end
      if (IMM_W < CIMM_W) begin : g_bad_imm
         $error("hint_cls_rvc: IMM_W too narrow for compressed immediate");
      end
      if (CREG_W >= REG_W) begin : g_bad_creg
         $error("hint_cls_rvc: CREG_W must be narrower than REG_W");
      end
   endgenerate

   logic [2:0]        f3;
   logic              b12;
   logic [4:0]        hi5;
   logic [4:0]        lo5;
   logic [1:0]        quad;
   logic [CIMM_W-1:0] imm6;
   logic              q01, q10;
   logic              hi_zero, lo_zero, imm_zero;

   assign f3       = half[15:13];
   assign b12      = half[12];
   assign hi5      = half[11:7];
   assign lo5      = half[6:2];
   assign quad     = half[1:0];
   assign imm6     = {b12, lo5};
   assign q01      = (quad == 2'b01);
   assign q10      = (quad == 2'b10);
   assign hi_zero  = (hi5 == 5'd0);
   assign lo_zero  = (lo5 == 5'd0);
   assign imm_zero = (imm6 == '0);

   logic m_nop, m_addi, m_li, m_lui, m_mv, m_add, m_slli, m_srli, m_srai;

   assign m_nop  = q01 && (f3 == 3'b000) && hi_zero && !imm_zero;
   assign m_addi = q01 && (f3 == 3'b000) && !b12 && lo_zero && !hi_zero;
   assign m_li   = q01 && (f3 == 3'b010) && hi_zero;
   assign m_lui  = q01 && (f3 == 3'b011) && hi_zero && !imm_zero;
   assign m_mv   = q10 && (f3 == 3'b100) && !b12 && hi_zero && !lo_zero;
   assign m_add  = q10 && (f3 == 3'b100) &&  b12 && hi_zero && !lo_zero;
   assign m_slli = q10 && (f3 == 3'b000) && (imm_zero || hi_zero) && (rv64 || !b12);
   assign m_srli = q01 && (f3 == 3'b100) && !b12 && (hi5[4:3] == 2'b00) && lo_zero;
   assign m_srai = q01 && (f3 == 3'b100) && !b12 && (hi5[4:3] == 2'b01) && lo_zero;

   logic [IMM_W-1:0] imm_ext;
   logic [REG_W-1:0] hi_reg;
   logic [REG_W-1:0] lo_reg;
   logic [REG_W-1:0] creg;

   assign imm_ext = {{IMM_PAD{1'b0}}, imm6};
   assign hi_reg  = REG_W'(hi5);
   assign lo_reg  = REG_W'(lo5);
   assign creg    = {CBASE_W'(1), hi5[CREG_W-1:0]};

   always_comb begin
      res = HC_NO_RESULT;
      if (m_nop) begin
         res.hit = 1'b1;
         res.cat = HC_C_NOP;
         res.imm = imm_ext;
      end else if (m_addi) begin
         res.hit = 1'b1;
         res.cat = HC_C_ADDI;
         res.rd  = hi_reg;
      end else if (m_li) begin
         res.hit = 1'b1;
         res.cat = HC_C_LI;
         res.imm = imm_ext;
      end else if (m_lui) begin
         res.hit = 1'b1;
         res.cat = HC_C_LUI;
         res.imm = imm_ext;
      end else if (m_mv) begin
         res.hit = 1'b1;
         res.cat = HC_C_MV;
         res.rs  = lo_reg;
      end else if (m_add) begin
         res.hit = 1'b1;
         res.cat = HC_C_ADD;
         res.rs  = lo_reg;
      end else if (m_slli) begin
         res.hit = 1'b1;
         res.cat = HC_C_SLLI;
         res.imm = imm_ext;
         res.rd  = hi_reg;
      end else if (m_srli) begin
         res.hit = 1'b1;
         res.cat = HC_C_SRLI;
         res.rd  = creg;
      end else if (m_srai) begin
         res.hit = 1'b1;
         res.cat = HC_C_SRAI;
         res.rd  = creg;
      end
   end

endmodule

// File: rtl/hint_cls_wide.sv
module hint_cls_wide
   import hint_cls_pkg::*;
#(
   parameter int ILEN  = 32,
   parameter int IMM_W = 12,
   parameter int REG_W = 5
) (
   input  logic [ILEN-1:0] word,
   output hc_result_t      res
);

   localparam logic [6:0] MISC_MEM_OP = 7'b0001111;
   localparam logic [2:0] F3_FENCE    = 3'b000;
   localparam logic [2:0] F3_FENCEI   = 3'b001;
   localparam logic [3:0] FM_PLAIN    = 4'b0000;
   localparam logic [3:0] FM_ORDERED  = 4'b1000;

   generate
      if (ILEN != HC_ILEN) begin : g_bad_ilen
         $error("hint_cls_wide: ILEN must be 32");
      end
      if (IMM_W != HC_IMM_W) begin : g_bad_imm
         $error("hint_cls_wide: IMM_W must be 12");
      end
   endgenerate

   logic [6:0]       opc;
   logic [2:0]       f3;
   logic [3:0]       fm;
   logic [IMM_W-1:0] upper;
   logic [REG_W-1:0] rs1;
   logic [REG_W-1:0] rd;
   logic             regs_nz;
   logic             misc_mem;

   assign opc      = word[6:0];
   assign f3       = word[14:12];
   assign fm       = word[31:28];
   assign upper    = word[31:20];
   assign rs1      = word[19:15];
   assign rd       = word[11:7];
   assign regs_nz  = (rs1 != '0) || (rd != '0);
   assign misc_mem = (opc == MISC_MEM_OP);

   logic m_fence, m_fencei;

   assign m_fence  = misc_mem && (f3 == F3_FENCE) &&
                     (((fm != FM_PLAIN) && (fm != FM_ORDERED)) || regs_nz);
   assign m_fencei = misc_mem && (f3 == F3_FENCEI) &&
                     ((upper != '0) || regs_nz);

   always_comb begin
      res = HC_NO_RESULT;
      if (m_fence || m_fencei) begin
         res.hit = 1'b1;
         res.cat = m_fence ? HC_FENCE_RSV : HC_FENCEI_RSV;
         res.imm = upper;
         res.rd  = rd;
         res.rs  = rs1;
      end
   end

endmodule

// File: rtl/hint_cls_stage.sv
module hint_cls_stage
   import hint_cls_pkg::*;
#(
   parameter int IMM_W = 12,
   parameter int REG_W = 5,
   parameter int CAT_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  hc_result_t       in_res,
   output logic             q_valid,
   output logic             q_hint,
   output logic [CAT_W-1:0] q_cat,
   output logic [IMM_W-1:0] q_imm,
   output logic [REG_W-1:0] q_rd,
   output logic [REG_W-1:0] q_rs
);

   generate
      if (CAT_W != HC_CAT_W) begin : g_bad_cat
         $error("hint_cls_stage: CAT_W must match the category enum");
      end
   endgenerate

   logic take;
   assign take = in_valid && in_res.hit;

   always_ff @(posedge clk) begin
      if (rst) begin
         q_valid <= 1'b0;
         q_hint  <= 1'b0;
         q_cat   <= '0;
         q_imm   <= '0;
         q_rd    <= '0;
         q_rs    <= '0;
      end else begin
         q_valid <= in_valid;
         q_hint  <= take;
         q_cat   <= take ? CAT_W'(in_res.cat) : '0;
         q_imm   <= take ? in_res.imm : '0;
         q_rd    <= take ? in_res.rd  : '0;
         q_rs    <= take ? in_res.rs  : '0;
      end
   end

endmodule

// File: rtl/hint_nop_classifier.sv
module hint_nop_classifier
   import hint_cls_pkg::*;
#(
   parameter int ILEN         = 32,
   parameter int IMM_W        = 12,
   parameter int REG_W        = 5,
   parameter int CAT_W        = 4,
   parameter bit SUPPORT_RV64 = 1'b1
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [ILEN-1:0]  in_word,
   input  logic             rv64_mode,
   output logic             out_valid,
   output logic             out_hint,
   output logic [CAT_W-1:0] out_cat,
   output logic [IMM_W-1:0] out_imm,
   output logic [REG_W-1:0] out_rd,
   output logic [REG_W-1:0] out_rs
);

   localparam int HALF_W = ILEN / 2;

   generate
      if (REG_W != HC_REG_W) begin : g_bad_reg
         $error("hint_nop_classifier: REG_W must be 5");
      end
   endgenerate

   logic rv64_eff;

   generate
      if (SUPPORT_RV64) begin : g_mode_pin
         assign rv64_eff = rv64_mode;
      end else begin : g_mode_fixed
         logic unused_mode;
         assign unused_mode = rv64_mode;
         assign rv64_eff    = 1'b0;
      end
   endgenerate

   hc_result_t res_rvc;
   hc_result_t res_wide;
   hc_result_t res_sel;
   logic       is_wide;

   hint_cls_rvc #(
      .HALF_W (HALF_W),
      .IMM_W  (IMM_W),
      .REG_W  (REG_W),
      .CREG_W (HC_CREG_W)
   ) u_rvc (
      .half (in_word[HALF_W-1:0]),
      .rv64 (rv64_eff),
      .res  (res_rvc)
   );

   hint_cls_wide #(
      .ILEN  (ILEN),
      .IMM_W (IMM_W),
      .REG_W (REG_W)
   ) u_wide (
      .word (in_word),
      .res  (res_wide)
   );

   assign is_wide = (in_word[1:0] == 2'b11);
   assign res_sel = is_wide ? res_wide : res_rvc;

   hint_cls_stage #(
      .IMM_W (IMM_W),
      .REG_W (REG_W),
      .CAT_W (CAT_W)
   ) u_stage (
      .clk      (clk),
      .rst      (rst),
      .in_valid (in_valid),
      .in_res   (res_sel),
      .q_valid  (out_valid),
      .q_hint   (out_hint),
      .q_cat    (out_cat),
      .q_imm    (out_imm),
      .q_rd     (out_rd),
      .q_rs     (out_rs)
   );

endmodule

// File: rtl/hint_cls_checker.sv
module hint_cls_checker #(
   parameter int ILEN  = 32,
   parameter int IMM_W = 12,
   parameter int REG_W = 5,
   parameter int CAT_W = 4
) (
   input logic             clk,
   input logic             rst,
   input logic             in_valid,
   input logic [ILEN-1:0]  in_word,
   input logic             rv64_mode,
   input logic             out_valid,
   input logic             out_hint,
   input logic [CAT_W-1:0] out_cat,
   input logic [IMM_W-1:0] out_imm,
   input logic [REG_W-1:0] out_rd,
   input logic [REG_W-1:0] out_rs
);

   localparam logic [CAT_W-1:0] K_NONE   = CAT_W'(0);
   localparam logic [CAT_W-1:0] K_SLLI   = CAT_W'(7);
   localparam logic [CAT_W-1:0] K_FENCE  = CAT_W'(10);
   localparam logic [CAT_W-1:0] K_FENCEI = CAT_W'(11);

   AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> (!out_valid && !out_hint && out_cat == K_NONE)); // R1

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (out_valid == $past(in_valid))); // R2

   AST_HINT_NEEDS_VALID: assert property (@(posedge clk) disable iff (rst)
      out_hint |-> out_valid); // R3

   AST_HINT_IFF_CATEGORY: assert property (@(posedge clk) disable iff (rst)
      out_hint == (out_cat != K_NONE)); // R12

   AST_CATEGORY_RANGE: assert property (@(posedge clk) disable iff (rst)
      out_cat <= K_FENCEI); // R12

   AST_NONE_FIELDS_ZERO: assert property (@(posedge clk) disable iff (rst)
      (out_cat == K_NONE) |-> (out_imm == '0 && out_rd == '0 && out_rs == '0)); // R11

   AST_SLLI_RV32_GUARD: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && out_cat == K_SLLI && !$past(rv64_mode)) |-> !$past(in_word[12])); // R7

   AST_FENCE_OPCODE: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && (out_cat == K_FENCE || out_cat == K_FENCEI))
         |-> ($past(in_word[6:0]) == 7'b0001111)); // R9

   AST_COMPRESSED_QUADRANT: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && out_hint && out_cat < K_FENCE) |-> ($past(in_word[1:0]) != 2'b11)); // R13

endmodule

bind hint_nop_classifier hint_cls_checker #(
   .ILEN  (ILEN),
   .IMM_W (IMM_W),
   .REG_W (REG_W),
   .CAT_W (CAT_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .in_word   (in_word),
   .rv64_mode (rv64_mode),
   .out_valid (out_valid),
   .out_hint  (out_hint),
   .out_cat   (out_cat),
   .out_imm   (out_imm),
   .out_rd    (out_rd),
   .out_rs    (out_rs)
);

// File: tb/hint_nop_classifier_bench.sv
`timescale 1ns/1ps
module hint_nop_classifier_bench;

   localparam int K_NONE = 0, K_NOP = 1, K_ADDI = 2, K_LI = 3, K_LUI = 4,
                  K_MV = 5, K_ADD = 6, K_SLLI = 7, K_SRLI = 8, K_SRAI = 9,
                  K_FENCE = 10, K_FENCEI = 11;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] in_word = '0;
   logic        rv64_mode = 1'b0;
   logic        out_valid, out_hint;
   logic [3:0]  out_cat;
   logic [11:0] out_imm;
   logic [4:0]  out_rd, out_rs;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   hint_nop_classifier u_hint_nop_classifier (
      .clk(clk), .rst(rst), .in_valid(in_valid), .in_word(in_word),
      .rv64_mode(rv64_mode), .out_valid(out_valid), .out_hint(out_hint),
      .out_cat(out_cat), .out_imm(out_imm), .out_rd(out_rd), .out_rs(out_rs)
   );

   function automatic logic [31:0] cw(input logic [2:0] f3, input logic b12,
                                      input logic [4:0] hi, input logic [4:0] lo,
                                      input logic [1:0] q);
      return {16'h0000, f3, b12, hi, lo, q};
   endfunction

   function automatic logic [31:0] fw(input logic [3:0] fm, input logic [3:0] pr,
                                      input logic [3:0] su, input logic [4:0] rs1,
                                      input logic [2:0] f3, input logic [4:0] rd);
      return {fm, pr, su, rs1, f3, rd, 7'b0001111};
   endfunction

   task automatic check(input string req, input logic v, input int cat,
                        input int imm, input int rd, input int rs);
      logic [4+1+1+12+5+5-1:0] act, exp;
      checks++;
      act = {out_cat, out_valid, out_hint, out_imm, out_rd, out_rs};
      exp = {4'(cat), v, (cat != 0), 12'(imm), 5'(rd), 5'(rs)};
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got valid=%0b hint=%0b cat=%0d imm=%h rd=%0d rs=%0d, expected valid=%0b hint=%0b cat=%0d imm=%h rd=%0d rs=%0d",
                  req, out_valid, out_hint, out_cat, out_imm, out_rd, out_rs,
                  v, (cat != 0), cat, 12'(imm), rd, rs);
      end
   endtask

   // present one valid word, sample one cycle later at the falling edge
   task automatic run(input string req, input logic [31:0] w, input logic m64,
                      input int cat, input int imm, input int rd, input int rs);
      @(negedge clk);
      in_valid  = 1'b1;
      in_word   = w;
      rv64_mode = m64;
      @(negedge clk);
      check(req, 1'b1, cat, imm, rd, rs);
   endtask

   task automatic t_reset();
      in_valid = 1'b1;
      in_word  = cw(3'b000, 1'b1, 5'd0, 5'd3, 2'b01);
      repeat (3) @(negedge clk);
      check("R1 reset", 1'b0, K_NONE, 0, 0, 0);
      rst = 1'b0;
      @(negedge clk);
      check("R1 first cycle after reset", 1'b1, K_NOP, 12'h023, 0, 0);
   endtask

   task automatic t_pipeline();
      @(negedge clk);
      in_valid = 1'b1;
      in_word  = cw(3'b010, 1'b0, 5'd0, 5'd9, 2'b01);
      @(negedge clk);
      check("R2 stream word A", 1'b1, K_LI, 9, 0, 0);
      in_word = cw(3'b100, 1'b0, 5'd0, 5'd6, 2'b10);
      #1;
      check("R2 no combinational path", 1'b1, K_LI, 9, 0, 0);
      @(negedge clk);
      check("R2 stream word B", 1'b1, K_MV, 0, 0, 6);
      in_valid = 1'b0;
      @(negedge clk);
      check("R2 valid drops after one cycle", 1'b0, K_NONE, 0, 0, 0);
   endtask

   task automatic t_invalid();
      @(negedge clk);
      in_valid = 1'b0;
      in_word  = fw(4'h1, 4'hF, 4'hF, 5'd3, 3'b000, 5'd2);
      @(negedge clk);
      check("R3 invalid reserved fence", 1'b0, K_NONE, 0, 0, 0);
      in_word = cw(3'b000, 1'b0, 5'd4, 5'd0, 2'b01);
      @(negedge clk);
      check("R3 invalid compressed hint", 1'b0, K_NONE, 0, 0, 0);
   endtask

   task automatic t_nop_addi();
      run("R4 nop hint", cw(3'b000, 1'b1, 5'd0, 5'd3, 2'b01), 1'b0, K_NOP, 12'h023, 0, 0);
      run("R4 nop hint low imm", cw(3'b000, 1'b0, 5'd0, 5'd1, 2'b01), 1'b0, K_NOP, 1, 0, 0);
      run("R4 addi hint", cw(3'b000, 1'b0, 5'd9, 5'd0, 2'b01), 1'b0, K_ADDI, 0, 9, 0);
      run("R4 real addi not hint", cw(3'b000, 1'b0, 5'd9, 5'd2, 2'b01), 1'b0, K_NONE, 0, 0, 0);
      run("R4 addi with b12 not hint", cw(3'b000, 1'b1, 5'd9, 5'd0, 2'b01), 1'b0, K_NONE, 0, 0, 0);
   endtask

   task automatic t_li_lui();
      run("R5 li hint", cw(3'b010, 1'b1, 5'd0, 5'h1F, 2'b01), 1'b0, K_LI, 12'h03F, 0, 0);
      run("R5 li hint zero imm", cw(3'b010, 1'b0, 5'd0, 5'd0, 2'b01), 1'b0, K_LI, 0, 0, 0);
      run("R5 li with rd not hint", cw(3'b010, 1'b0, 5'd1, 5'd4, 2'b01), 1'b0, K_NONE, 0, 0, 0);
      run("R5 lui hint", cw(3'b011, 1'b0, 5'd0, 5'd4, 2'b01), 1'b0, K_LUI, 4, 0, 0);
      run("R5 lui zero imm not hint", cw(3'b011, 1'b0, 5'd0, 5'd0, 2'b01), 1'b0, K_NONE, 0, 0, 0);
   endtask

   task automatic t_mv_add();
      run("R6 mv hint", cw(3'b100, 1'b0, 5'd0, 5'd7, 2'b10), 1'b0, K_MV, 0, 0, 7);
      run("R6 add hint", cw(3'b100, 1'b1, 5'd0, 5'd31, 2'b10), 1'b0, K_ADD, 0, 0, 31);
      run("R6 ebreak not hint", cw(3'b100, 1'b1, 5'd0, 5'd0, 2'b10), 1'b0, K_NONE, 0, 0, 0);
      run("R6 real mv not hint", cw(3'b100, 1'b0, 5'd3, 5'd7, 2'b10), 1'b0, K_NONE, 0, 0, 0);
   endtask

   task automatic t_slli();
      run("R7 slli zero shift", cw(3'b000, 1'b0, 5'd5, 5'd0, 2'b10), 1'b0, K_SLLI, 0, 5, 0);
      run("R7 slli zero rd", cw(3'b000, 1'b0, 5'd0, 5'd3, 2'b10), 1'b0, K_SLLI, 3, 0, 0);
      run("R7 slli b12 in rv32", cw(3'b000, 1'b1, 5'd0, 5'd3, 2'b10), 1'b0, K_NONE, 0, 0, 0);
      run("R7 slli b12 in rv64", cw(3'b000, 1'b1, 5'd0, 5'd3, 2'b10), 1'b1, K_SLLI, 12'h023, 0, 0);
      run("R7 real slli not hint", cw(3'b000, 1'b0, 5'd5, 5'd3, 2'b10), 1'b1, K_NONE, 0, 0, 0);
   endtask

   task automatic t_shift_right();
      run("R8 srli hint", cw(3'b100, 1'b0, 5'b00010, 5'd0, 2'b01), 1'b0, K_SRLI, 0, 10, 0);
      run("R8 srai hint", cw(3'b100, 1'b0, 5'b01111, 5'd0, 2'b01), 1'b0, K_SRAI, 0, 15, 0);
      run("R8 srli b12 not hint", cw(3'b100, 1'b1, 5'b00010, 5'd0, 2'b01), 1'b1, K_NONE, 0, 0, 0);
      run("R8 srai shamt not hint", cw(3'b100, 1'b0, 5'b01010, 5'd2, 2'b01), 1'b0, K_NONE, 0, 0, 0);
      run("R8 andi not hint", cw(3'b100, 1'b0, 5'b10010, 5'd0, 2'b01), 1'b0, K_NONE, 0, 0, 0);
   endtask

   task automatic t_fence();
      run("R9 fm reserved", fw(4'h1, 4'hF, 4'hF, 5'd0, 3'b000, 5'd0), 1'b0, K_FENCE, 12'h1FF, 0, 0);
      run("R9 rs1 nonzero", fw(4'h0, 4'hF, 4'hF, 5'd3, 3'b000, 5'd0), 1'b0, K_FENCE, 12'h0FF, 0, 3);
      run("R9 rd nonzero", fw(4'h8, 4'h3, 4'h3, 5'd0, 3'b000, 5'd4), 1'b0, K_FENCE, 12'h833, 4, 0);
      run("R11 standard fence", 32'h0FF0000F, 1'b0, K_NONE, 0, 0, 0);
      run("R11 ordered fence", 32'h8330000F, 1'b0, K_NONE, 0, 0, 0);
   endtask

   task automatic t_fencei();
      run("R10 imm nonzero", fw(4'h0, 4'h0, 4'h1, 5'd0, 3'b001, 5'd0), 1'b0, K_FENCEI, 1, 0, 0);
      run("R10 rs1 nonzero", fw(4'h0, 4'h0, 4'h0, 5'd2, 3'b001, 5'd0), 1'b0, K_FENCEI, 0, 0, 2);
      run("R10 rd nonzero", fw(4'h0, 4'h0, 4'h0, 5'd0, 3'b001, 5'd1), 1'b0, K_FENCEI, 0, 1, 0);
      run("R11 plain ifetch fence", 32'h0000100F, 1'b0, K_NONE, 0, 0, 0);
   endtask

   task automatic t_none_and_width();
      run("R11 plain c.nop", 32'h00000001, 1'b0, K_NONE, 0, 0, 0);
      run("R11 all zero", 32'h00000000, 1'b0, K_NONE, 0, 0, 0);
      run("R12 reserved fence code", fw(4'hF, 4'h0, 4'h0, 5'd0, 3'b000, 5'd0), 1'b0, K_FENCE, 12'hF00, 0, 0);
      run("R13 upper half ignored", {16'hFFFF, cw(3'b000, 1'b1, 5'd0, 5'd3, 2'b01)[15:0]}, 1'b0, K_NOP, 12'h023, 0, 0);
      run("R13 upper half ignored on mv", {16'h100F, cw(3'b100, 1'b0, 5'd0, 5'd7, 2'b10)[15:0]}, 1'b0, K_MV, 0, 0, 7);
      run("R13 wide word not compressed", 32'h00000013, 1'b0, K_NONE, 0, 0, 0);
      run("R13 wide word funct3 other", fw(4'h1, 4'h0, 4'h0, 5'd0, 3'b010, 5'd0), 1'b0, K_NONE, 0, 0, 0);
   endtask

   initial begin
      t_reset();
      t_pipeline();
      t_invalid();
      t_nop_addi();
      t_li_lui();
      t_mv_add();
      t_slli();
      t_shift_right();
      t_fence();
      t_fencei();
      t_none_and_width();
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: got run still busy, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule